// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Read Sequencer

This block runs one conversion-and-readout cycle on a multichannel simultaneous-sampling converter that has a parallel result bus. A start request in idle first waits out a programmable quiet interval, during which the bus has carried no read. The block then pulses the conversion strobe for one cycle. It reads results while the conversion is still running. Each falling edge of the converter's end-of-conversion flag causes one read strobe, and the 14-bit word on the bus is captured while that strobe is low.

Each captured word leaves the block as a one-cycle valid pulse with a channel index that counts up from zero. The cycle ends when the converter's end-of-last-conversion flag is found low at a read. That read carries a done pulse. A watchdog counter bounds every wait for the next result. If it expires, the block drops back to idle with an error pulse. The chip-select output follows one of three policies chosen at run time.

All converter inputs are taken as synchronous to `clk`.

Top module: `adc_readout_seq`

## Requirements
- R1: While reset is asserted and after it, with no start request, `convst` is low, `rd_n` is high, and `busy`, `out_valid`, `done` and `err` are low.
- R2: A `start` sampled high in idle produces exactly one `convst` pulse, one cycle wide. A `start` sampled while `busy` is high has no effect.
- R3: Between the last cycle with `rd_n` low and the cycle with `convst` high, there are at least `quiet_cycles`+1 cycles with `rd_n` high. If a new start is sampled on the first edge after `done`, exactly `quiet_cycles`+1 such cycles separate them (for `quiet_cycles` >= 1).
- R4: When `eoc_n` is seen falling at a clock edge while a result is awaited, `rd_n` is low during the second cycle after that edge. `out_valid` is high in the cycle after that.
- R5: `out_chan` is 0 for the first result of a cycle and increases by one for each later result.
- R6: `out_data` equals the value that `adc_data` carried at the clock edge ending the `rd_n`-low cycle.
- R7: A read taken while `eolc_n` is low is the last one. `done` is high together with its `out_valid`, the block returns to idle, and any later `eoc_n` fall causes no read and no output.
- R8: `cs_mode` selects the chip-select policy:
  - 0: `cs_n` stays low.
  - 1: `cs_n` is low for exactly the cycle before each read strobe and the read-strobe cycle itself.
  - 2 or 3: `cs_n` equals `rd_n`.
- R9: After `convst`, or after each read, if no `eoc_n` fall is seen within `timeout_cycles`+1 waiting cycles, `err` pulses `timeout_cycles`+2 cycles after that `convst`/read cycle. No output is produced and the block returns to idle.
- R10: `busy` is high from the cycle after a start is accepted until the cycle in which `done` or `err` pulses. It is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one conversion-and-readout cycle |
| quiet_cycles | input | CNT_W | Minimum idle-bus cycles before a conversion strobe |
| timeout_cycles | input | CNT_W | Watchdog limit while awaiting a result |
| cs_mode | input | 2 | Chip-select policy |
| eoc_n | input | 1 | Converter end-of-conversion flag, active low |
| eolc_n | input | 1 | Converter end-of-last-conversion flag, active low |
| adc_data | input | DATA_W | Converter parallel result bus |
| convst | output | 1 | Conversion start strobe |
| rd_n | output | 1 | Read strobe, active low |
| cs_n | output | 1 | Chip select, active low |
| busy | output | 1 | A cycle is in progress |
| out_valid | output | 1 | Captured result valid |
| out_chan | output | $clog2(CH_MAX) | Channel index of the captured result |
| out_data | output | DATA_W | Captured result |
| done | output | 1 | Last result delivered |
| err | output | 1 | Result wait timed out |

## Verification
The bench counts edges from a reference event.

- From the falling edge it drives on `eoc_n`, the read strobe is due two cycles later and the output word three cycles later.
- The timeout error is due `timeout_cycles`+2 cycles after the strobe or read that opened the wait.
- The conversion strobe after an immediate restart is due after exactly `quiet_cycles`+1 idle read-strobe cycles.

The converter model and the monitor both act on the falling clock edge. Each stamps events with one shared posedge counter, so every expected latency is compared as an exact difference of cycle numbers. Nothing is sampled near an active edge.

// File: rtl/adc_readout_seq.sv
module adc_readout_seq #(
  parameter int DATA_W = 14,
  parameter int CH_MAX = 8,
  parameter int CNT_W  = 16,
  localparam int CH_W  = $clog2(CH_MAX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  quiet_cycles,
  input  logic [CNT_W-1:0]  timeout_cycles,
  input  logic [1:0]        cs_mode,
  input  logic              eoc_n,
  input  logic              eolc_n,
  input  logic [DATA_W-1:0] adc_data,
  output logic              convst,
  output logic              rd_n,
  output logic              cs_n,
  output logic              busy,
  output logic              out_valid,
  output logic [CH_W-1:0]   out_chan,
  output logic [DATA_W-1:0] out_data,
  output logic              done,
  output logic              err
);

  typedef enum logic [2:0] {S_IDLE, S_QUIET, S_CONV, S_WAIT, S_SETUP, S_READ} state_t;

  state_t           state;
  logic [CNT_W-1:0] wait_cnt;
  logic [CNT_W-1:0] idle_cnt;
  logic [CH_W-1:0]  chan;
  logic             eoc_q;
  logic             eoc_fall;

  assign eoc_fall = eoc_q & ~eoc_n;
  assign convst   = (state == S_CONV);
  assign rd_n     = (state != S_READ);
  assign busy     = (state != S_IDLE);

  always_comb begin
    case (cs_mode)
      2'd0:    cs_n = 1'b0;
      2'd1:    cs_n = !(state == S_SETUP || state == S_READ);
      default: cs_n = rd_n;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      wait_cnt  <= '0;
      idle_cnt  <= '1;
      chan      <= '0;
      eoc_q     <= 1'b1;
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_data  <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      eoc_q     <= eoc_n;
      out_valid <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      if (state == S_READ)  idle_cnt <= '0;
      else if (!(&idle_cnt)) idle_cnt <= idle_cnt + 1'b1;

      case (state)
        S_IDLE:  if (start) state <= S_QUIET;
        S_QUIET: if (idle_cnt >= quiet_cycles) state <= S_CONV;
        S_CONV: begin
          state    <= S_WAIT;
          wait_cnt <= '0;
          chan     <= '0;
        end
        S_WAIT: begin
          if (eoc_fall) state <= S_SETUP;
          else if (wait_cnt == timeout_cycles) begin
            err   <= 1'b1;
            state <= S_IDLE;
          end else wait_cnt <= wait_cnt + 1'b1;
        end
        S_SETUP: state <= S_READ;
        S_READ: begin
          out_valid <= 1'b1;
          out_chan  <= chan;
          out_data  <= adc_data;
          chan      <= chan + 1'b1;
          wait_cnt  <= '0;
          if (!eolc_n) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else state <= S_WAIT;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_readout_seq_chk.sv
module adc_readout_seq_chk #(
  parameter int DATA_W = 14,
  parameter int CH_MAX = 8,
  parameter int CNT_W  = 16,
  localparam int CH_W  = $clog2(CH_MAX)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CNT_W-1:0] quiet_cycles,
  input logic [1:0]       cs_mode,
  input logic             convst,
  input logic             rd_n,
  input logic             cs_n,
  input logic             busy,
  input logic             out_valid,
  input logic             done,
  input logic             err
);

  logic [CNT_W:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            hi_cnt <= '1;
    else if (!rd_n)        hi_cnt <= '0;
    else if (!(&hi_cnt))   hi_cnt <= hi_cnt + 1'b1;
  end

  AST_CONVST_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) convst |=> !convst); // R2
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start)); // R2
  AST_QUIET_GAP:      assert property (@(posedge clk) disable iff (!rst_n) convst |-> hi_cnt > {1'b0, quiet_cycles}); // R3
  AST_VALID_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> $past(!rd_n)); // R4
  AST_DONE_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n) done |-> out_valid); // R7
  AST_RD_SELECTED:    assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !cs_n); // R8
  AST_CS_FOLLOWS_RD:  assert property (@(posedge clk) disable iff (!rst_n) cs_mode[1] |-> cs_n == rd_n); // R8
  AST_CS_HELD:        assert property (@(posedge clk) disable iff (!rst_n) cs_mode == 2'd0 |-> !cs_n); // R8
  AST_ERR_SILENT:     assert property (@(posedge clk) disable iff (!rst_n) err |-> !out_valid && !done); // R9
  AST_END_IDLE:       assert property (@(posedge clk) disable iff (!rst_n) (done || err) |-> !busy); // R10

endmodule

bind adc_readout_seq adc_readout_seq_chk #(
  .DATA_W(DATA_W), .CH_MAX(CH_MAX), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .quiet_cycles(quiet_cycles),
  .cs_mode(cs_mode), .convst(convst), .rd_n(rd_n), .cs_n(cs_n),
  .busy(busy), .out_valid(out_valid), .done(done), .err(err)
);

// File: tb/adc_readout_seq_tb_top.sv
module adc_readout_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] quiet_cycles = 16'd0;
  logic [15:0] timeout_cycles = 16'd100;
  logic [1:0]  cs_mode = 2'd2;
  logic        eoc_n = 1'b1;
  logic        eolc_n = 1'b1;
  logic [13:0] adc_data = 14'h3FFF;
  logic        convst, rd_n, cs_n, busy, out_valid, done, err;
  logic [2:0]  out_chan;
  logic [13:0] out_data;

  always #4 clk = ~clk;

  adc_readout_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .quiet_cycles(quiet_cycles),
    .timeout_cycles(timeout_cycles), .cs_mode(cs_mode), .eoc_n(eoc_n),
    .eolc_n(eolc_n), .adc_data(adc_data), .convst(convst), .rd_n(rd_n),
    .cs_n(cs_n), .busy(busy), .out_valid(out_valid), .out_chan(out_chan),
    .out_data(out_data), .done(done), .err(err)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [13:0] dval(int s, int k);
    return 14'((s * 977 + k * 613 + 5) % 16384);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model
  int cfg_n = 1, cfg_hang = 1, cfg_first = 17, cfg_gap = 3, cfg_seed = 0;
  bit cfg_extra = 0;
  bit m_arm = 0;
  int m_t = 0, m_k = 0;
  logic [13:0] rd_word = 14'd0;
  int fall_cyc [8];

  always @(negedge clk) begin
    if (convst) begin
      m_arm = 1; m_t = 0; m_k = 0; eoc_n = 1'b1; eolc_n = 1'b1;
    end else if (m_arm) begin
      m_t++;
      eoc_n = 1'b1;
      if (m_k < cfg_n && m_k < cfg_hang && m_t == cfg_first + m_k * cfg_gap) begin
        eoc_n = 1'b0;
        rd_word = dval(cfg_seed, m_k);
        fall_cyc[m_k] = cyc;
        if (m_k == cfg_n - 1) eolc_n = 1'b0;
        m_k++;
      end else if (cfg_extra && m_k == cfg_n && m_t == cfg_first + m_k * cfg_gap) begin
        eoc_n = 1'b0;
      end
    end
    adc_data = rd_n ? 14'h3FFF : rd_word;
  end

  // monitor
  int nv, nr, ncs, csbad, ndone, nerr, nconv, err_cyc, conv_cyc, gap;
  int hi_run = 1000;
  logic cv_prev = 1'b0;
  int v_chan [16];
  int v_data [16];
  int v_cyc  [16];
  bit v_done [16];
  int rdlo_cyc [16];

  task automatic clear_stats();
    nv = 0; nr = 0; ncs = 0; csbad = 0; ndone = 0; nerr = 0; nconv = 0;
    err_cyc = 0; conv_cyc = 0; gap = -1;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && nv < 16) begin
        v_chan[nv] = int'(out_chan); v_data[nv] = int'(out_data);
        v_cyc[nv] = cyc; v_done[nv] = done; nv++;
      end
      if (!rd_n && nr < 16) begin rdlo_cyc[nr] = cyc; nr++; end
      if (!cs_n) ncs++;
      if (cs_mode == 2'd0 && cs_n) csbad++;
      if (cs_mode[1] && cs_n != rd_n) csbad++;
      if (!rd_n && cs_n) csbad++;
      if (done) ndone++;
      if (err) begin nerr++; err_cyc = cyc; end
      if (convst && !cv_prev) begin nconv++; conv_cyc = cyc; gap = hi_run; end
      cv_prev = convst;
      hi_run = rd_n ? hi_run + 1 : 0;
    end
  end

  bit busy_mid;

  task automatic run(int n, int hang, bit extra, logic [1:0] mode, int q, int tmo,
                     int seed, int gp, bit poke);
    clear_stats();
    cfg_n = n; cfg_hang = hang; cfg_extra = extra; cfg_seed = seed; cfg_gap = gp;
    cs_mode = mode; quiet_cycles = 16'(q); timeout_cycles = 16'(tmo);
    busy_mid = 0;
    start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1;
      if (i == 5) busy_mid = busy;
      if (poke && i == 10) start = 1'b1;
      if (i == 11) start = 1'b0;
      if (ndone > 0 || nerr > 0) break;
    end
  endtask

  task automatic check_good(int n, logic [1:0] mode, int seed, string tag);
    chk(nconv == 1, "R2 one strobe", nconv, 1);
    chk(busy_mid == 1, "R10 busy in cycle", int'(busy_mid), 1);
    chk(busy == 0, "R10 idle at end", int'(busy), 0);
    chk(ndone == 1 && nerr == 0, "R7 done once, no err", ndone * 10 + nerr, 10);
    chk(nv == n, "R4 result count", nv, n);
    for (int k = 0; k < n && k < nv; k++) begin
      chk(v_chan[k] == k, "R5 channel index", v_chan[k], k);
      chk(v_data[k] == int'(dval(seed, k)), "R6 captured word", v_data[k], int'(dval(seed, k)));
      chk(rdlo_cyc[k] - fall_cyc[k] == 2, "R4 read strobe latency", rdlo_cyc[k] - fall_cyc[k], 2);
      chk(v_cyc[k] - fall_cyc[k] == 3, "R4 valid latency", v_cyc[k] - fall_cyc[k], 3);
      chk(v_done[k] == (k == n - 1), "R7 done with last", int'(v_done[k]), int'(k == n - 1));
    end
    chk(csbad == 0, "R8 chip-select policy", csbad, 0);
    if (mode == 2'd1) chk(ncs == 2 * n, "R8 framed cs cycles", ncs, 2 * n);
    if (tag.len() == 0) chk(1'b1, "", 0, 0);
  endtask

  task automatic t_reset();
    chk(convst == 0 && rd_n == 1 && busy == 0, "R1 strobes idle", {convst, rd_n, busy}, 3'b010);
    chk(out_valid == 0 && done == 0 && err == 0, "R1 flags low", {out_valid, done, err}, 0);
  endtask

  task automatic t_two_follow();
    run(2, 2, 0, 2'd2, 0, 100, 3, 3, 0);
    check_good(2, 2'd2, 3, "a");
  endtask

  task automatic t_eight_framed_then_restart();
    run(8, 8, 0, 2'd1, 5, 100, 7, 3, 0);
    check_good(8, 2'd1, 7, "b");
    chk(gap >= 6, "R3 gap after long idle", gap, 6);
    run(1, 1, 0, 2'd0, 5, 100, 11, 3, 0);
    check_good(1, 2'd0, 11, "c");
    chk(gap == 6, "R3 exact gap on immediate restart", gap, 6);
  endtask

  task automatic t_busy_start();
    run(4, 4, 0, 2'd3, 2, 100, 21, 5, 1);
    check_good(4, 2'd3, 21, "d");
    repeat (40) @(negedge clk);
    #1 chk(nconv == 1, "R2 start while busy ignored", nconv, 1);
  endtask

  task automatic t_extra_fall();
    int nv0, nr0;
    run(3, 3, 1, 2'd2, 1, 100, 33, 3, 0);
    check_good(3, 2'd2, 33, "e");
    nv0 = nv; nr0 = nr;
    repeat (10) @(negedge clk);
    #1;
    chk(nv == nv0, "R7 no output after last", nv, nv0);
    chk(nr == nr0, "R7 no read after last", nr, nr0);
  endtask

  task automatic t_timeout_first();
    run(2, 0, 0, 2'd2, 0, 10, 40, 3, 0);
    chk(nerr == 1 && ndone == 0, "R9 err not done", nerr * 10 + ndone, 10);
    chk(nv == 0, "R9 no output", nv, 0);
    chk(err_cyc - conv_cyc == 12, "R9 err timing", err_cyc - conv_cyc, 12);
    chk(busy == 0, "R10 idle after err", int'(busy), 0);
  endtask

  task automatic t_timeout_later();
    run(5, 2, 0, 2'd1, 0, 20, 50, 3, 0);
    chk(nerr == 1 && ndone == 0, "R9 err after two reads", nerr * 10 + ndone, 10);
    chk(nv == 2, "R9 outputs before err", nv, 2);
    if (nr >= 2)
      chk(err_cyc - rdlo_cyc[1] == 22, "R9 err timing after read", err_cyc - rdlo_cyc[1], 22);
    else chk(0, "R9 reads before err", nr, 2);
  endtask

  task automatic t_recover();
    run(3, 3, 0, 2'd0, 3, 100, 60, 4, 0);
    check_good(3, 2'd0, 60, "f");
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    #1;
    t_two_follow();
    t_eight_framed_then_restart();
    t_busy_start();
    t_extra_fall();
    t_timeout_first();
    t_timeout_later();
    t_recover();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule